// File: doc/BRIEF.md
# Function-selectable ALU slice

This block is a purely combinational arithmetic-logic slice, four bits wide by default. Two operands, a four-bit function code and a mode bit together pick one of 32 operations. With the mode bit high the slice applies one of the sixteen possible two-input Boolean functions to each bit pair on its own. With the mode bit low it adds two operand-derived terms chosen by the function code, plus an optional carry. The resulting set includes plain addition, subtraction, decrement and doubling, along with less common sums such as A plus (A AND NOT B).

Several slices chain into a wider datapath in one of two ways. In the first, each slice's carry output feeds the next slice's carry input. In the second, an external lookahead unit consumes each slice's group propagate and group generate outputs. An all-ones flag is raised whenever every result bit is 1. With the subtract code and no carry, this flag reports operand equality. Combined with the carry output, it gives a magnitude comparison. All operands and results are active high. The carry input, the carry output and the group propagate and generate outputs are active low.

Top module: `alu_slice`

## Requirements
- R1: With `logic_mode` = 1, `result` follows the function code (0 to 15) as: NOT A, NOR, (NOT A) AND B, 0, NAND, NOT B, XOR, A AND NOT B, (NOT A) OR B, XNOR, B, AND, all ones, A OR NOT B, OR, A. This includes code 6 = XOR, code 11 = AND and code 14 = OR.
- R2: With `logic_mode` = 1, `carry_in_n` has no effect on `result`.
- R3: With `logic_mode` = 0 and `carry_in_n` = 1 (no carry), `result` is the following function of the code, modulo 2^WIDTH: A, A|B, A|~B, -1, A+(A&~B), (A|B)+(A&~B), A-B-1, (A&~B)-1, A+(A&B), A+B, (A|~B)+(A&B), (A&B)-1, A+A, (A|B)+A, (A|~B)+A, A-1.
- R4: With `logic_mode` = 0 and `carry_in_n` = 0, `result` is the R3 value plus one, modulo 2^WIDTH. For example, code 6 then gives A-B.
- R5: `carry_out_n` is 0 exactly when the unreduced R3/R4 sum reaches 2^WIDTH, in either mode. Subtraction is formed as A plus the ones complement of B, so for code 6 `carry_out_n` = 0 means no borrow.
- R6: `prop_n` and `gen_n` do not depend on `carry_in_n`. `gen_n` is 0 exactly when the sum without carry reaches 2^WIDTH. Active high, carry out equals generate OR (propagate AND carry in).
- R7: `all_ones` is 1 exactly when every `result` bit is 1. With code 6, `logic_mode` = 0 and `carry_in_n` = 1, it is 1 exactly when A equals B.
- R8: With code 6, `logic_mode` = 0 and `carry_in_n` = 1, A > B exactly when `carry_out_n` = 0. A < B exactly when `carry_out_n` = 1 and `all_ones` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| fn_sel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in_n | input | 1 | Carry input, active low |
| result | output | WIDTH | Function result |
| carry_out_n | output | 1 | Carry output, active low |
| prop_n | output | 1 | Group carry propagate, active low |
| gen_n | output | 1 | Group carry generate, active low |
| all_ones | output | 1 | High when every result bit is 1 |

## Verification
The bench builds the slice with its default WIDTH of 4. At that width the whole input space is only 2 x 16 x 256 x 2 points, so every mode, function code, operand pair and carry value is applied. Every code's logic function and arithmetic sum, every carry-out boundary, and every equality and magnitude case of the subtract code are therefore covered. The carry input is toggled last for each operand pair, which exposes any dependence of the group outputs, or of logic-mode results, on that input.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int unsigned SLICE_W = 4;
    localparam int unsigned SEL_W   = 4;

    // Function codes that carry special meaning for checking
    typedef enum logic [SEL_W-1:0] {
        SEL_DIFF = 4'd6,   // XOR in logic mode, A-B-1 in arithmetic mode
        SEL_SUM  = 4'd9,   // XNOR in logic mode, A+B in arithmetic mode
        SEL_CONJ = 4'd11,  // AND in logic mode
        SEL_DISJ = 4'd14   // OR in logic mode
    } sel_code_e;

endpackage

// File: rtl/alu_slice_terms.sv
// Per-bit decode of the function code into the two addend terms.
// Term "wide" always covers term "narrow", so wide acts as the per-bit
// propagate and narrow as the per-bit generate.
module alu_slice_terms #(
    parameter int unsigned WIDTH = alu_slice_pkg::SLICE_W
) (
    input  logic [WIDTH-1:0]                  op_a,
    input  logic [WIDTH-1:0]                  op_b,
    input  logic [alu_slice_pkg::SEL_W-1:0]   fn_sel,
    output logic [WIDTH-1:0]                  term_wide,
    output logic [WIDTH-1:0]                  term_narrow
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign term_wide[i]   = op_a[i]
                              | (op_b[i]  & fn_sel[0])
                              | (~op_b[i] & fn_sel[1]);
        assign term_narrow[i] = (op_a[i] & ~op_b[i] & fn_sel[2])
                              | (op_a[i] &  op_b[i] & fn_sel[3]);
    end

endmodule

// File: rtl/alu_slice_carry.sv
// Fully expanded lookahead: every internal carry is a flat sum of
// products of the per-bit terms and the incoming carry.
module alu_slice_carry #(
    parameter int unsigned WIDTH = alu_slice_pkg::SLICE_W
) (
    input  logic [WIDTH-1:0] bit_prop,
    input  logic [WIDTH-1:0] bit_gen,
    input  logic             carry_in,
    output logic [WIDTH:0]   carry,
    output logic             grp_prop,
    output logic             grp_gen
);

    logic prod_c;
    logic prod_g;

    always_comb begin
        carry  = '0;
        prod_c = 1'b0;
        for (int i = 0; i <= WIDTH; i++) begin
            prod_c = carry_in;
            for (int k = 0; k < i; k++) begin
                prod_c = prod_c & bit_prop[k];
            end
            carry[i] = prod_c;
            for (int j = 0; j < i; j++) begin
                prod_c = bit_gen[j];
                for (int k = j + 1; k < i; k++) begin
                    prod_c = prod_c & bit_prop[k];
                end
                carry[i] = carry[i] | prod_c;
            end
        end
    end

    always_comb begin
        grp_prop = &bit_prop;
        grp_gen  = 1'b0;
        prod_g   = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            prod_g = bit_gen[j];
            for (int k = j + 1; k < WIDTH; k++) begin
                prod_g = prod_g & bit_prop[k];
            end
            grp_gen = grp_gen | prod_g;
        end
    end

endmodule

// File: rtl/alu_slice_result.sv
// Result formation: the half-sum XOR the incoming carry. Logic mode forces
// every carry high, which turns each bit into an inverted half-sum.
module alu_slice_result #(
    parameter int unsigned WIDTH = alu_slice_pkg::SLICE_W
) (
    input  logic [WIDTH-1:0] term_wide,
    input  logic [WIDTH-1:0] term_narrow,
    input  logic [WIDTH-1:0] bit_carry,
    input  logic             logic_mode,
    output logic [WIDTH-1:0] result,
    output logic             all_ones
);

    logic [WIDTH-1:0] half_sum;
    logic [WIDTH-1:0] eff_carry;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign half_sum[i]  = term_wide[i] & ~term_narrow[i];
        assign eff_carry[i] = logic_mode | bit_carry[i];
        assign result[i]    = half_sum[i] ^ eff_carry[i];
    end

    assign all_ones = &result;

endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
    parameter int unsigned WIDTH = alu_slice_pkg::SLICE_W
) (
    input  logic [WIDTH-1:0]                op_a,
    input  logic [WIDTH-1:0]                op_b,
    input  logic [alu_slice_pkg::SEL_W-1:0] fn_sel,
    input  logic                            logic_mode,
    input  logic                            carry_in_n,
    output logic [WIDTH-1:0]                result,
    output logic                            carry_out_n,
    output logic                            prop_n,
    output logic                            gen_n,
    output logic                            all_ones
);

    logic [WIDTH-1:0] term_wide;
    logic [WIDTH-1:0] term_narrow;
    logic [WIDTH:0]   carry;
    logic             grp_prop;
    logic             grp_gen;

    alu_slice_terms #(.WIDTH(WIDTH)) u_terms (
        .op_a        (op_a),
        .op_b        (op_b),
        .fn_sel      (fn_sel),
        .term_wide   (term_wide),
        .term_narrow (term_narrow)
    );

    alu_slice_carry #(.WIDTH(WIDTH)) u_carry (
        .bit_prop (term_wide),
        .bit_gen  (term_narrow),
        .carry_in (~carry_in_n),
        .carry    (carry),
        .grp_prop (grp_prop),
        .grp_gen  (grp_gen)
    );

    alu_slice_result #(.WIDTH(WIDTH)) u_result (
        .term_wide   (term_wide),
        .term_narrow (term_narrow),
        .bit_carry   (carry[WIDTH-1:0]),
        .logic_mode  (logic_mode),
        .result      (result),
        .all_ones    (all_ones)
    );

    assign carry_out_n = ~carry[WIDTH];
    assign prop_n      = ~grp_prop;
    assign gen_n       = ~grp_gen;

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
    parameter int unsigned WIDTH = alu_slice_pkg::SLICE_W
) (
    input logic [WIDTH-1:0]                op_a,
    input logic [WIDTH-1:0]                op_b,
    input logic [alu_slice_pkg::SEL_W-1:0] fn_sel,
    input logic                            logic_mode,
    input logic                            carry_in_n,
    input logic [WIDTH-1:0]                result,
    input logic                            carry_out_n,
    input logic                            prop_n,
    input logic                            gen_n,
    input logic                            all_ones
);
    import alu_slice_pkg::*;

    logic known;
    logic [WIDTH:0] ref_sum;

    assign known   = !$isunknown({op_a, op_b, fn_sel, logic_mode, carry_in_n});
    assign ref_sum = {1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(!carry_in_n);

    always_comb begin
        if (known) begin
            p_group_carry_r6: assert (!carry_out_n == (!gen_n || (!prop_n && !carry_in_n)));
            if (!logic_mode && fn_sel == SEL_DIFF && carry_in_n) begin
                p_equal_detect_r7: assert (all_ones == (op_a == op_b));
                p_greater_r8:      assert (!carry_out_n == (op_a > op_b));
            end
            if (!logic_mode && fn_sel == SEL_SUM) begin
                p_add_sum_r5: assert ({!carry_out_n, result} == ref_sum);
            end
            if (logic_mode && fn_sel == SEL_CONJ) begin
                p_logic_and_r1: assert (result == (op_a & op_b));
            end
            if (logic_mode && fn_sel == SEL_DISJ) begin
                p_logic_or_r1: assert (result == (op_a | op_b));
            end
            if (logic_mode && fn_sel == SEL_DIFF) begin
                p_logic_xor_r1: assert (result == (op_a ^ op_b));
            end
        end
    end

endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_alu_slice.sv
module test_alu_slice;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [3:0] fn_sel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in_n = 1'b1;
    logic [3:0] result;
    logic       carry_out_n;
    logic       prop_n;
    logic       gen_n;
    logic       all_ones;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alu_slice #(.WIDTH(4)) i_alu_slice (
        .op_a        (op_a),
        .op_b        (op_b),
        .fn_sel      (fn_sel),
        .logic_mode  (logic_mode),
        .carry_in_n  (carry_in_n),
        .result      (result),
        .carry_out_n (carry_out_n),
        .prop_n      (prop_n),
        .gen_n       (gen_n),
        .all_ones    (all_ones)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (mode=%0d code=%0d a=%0d b=%0d cin_n=%0d)",
                     tag, act, exp, logic_mode, fn_sel, op_a, op_b, carry_in_n);
        end
    endtask

    // Behavioural logic function per code
    function automatic int ref_logic(input int s, input int a, input int b);
        int na = (~a) & 15;
        int nb = (~b) & 15;
        case (s)
            0:  return na;
            1:  return (~(a | b)) & 15;
            2:  return na & b;
            3:  return 0;
            4:  return (~(a & b)) & 15;
            5:  return nb;
            6:  return a ^ b;
            7:  return a & nb;
            8:  return na | b;
            9:  return (~(a ^ b)) & 15;
            10: return b;
            11: return a & b;
            12: return 15;
            13: return a | nb;
            14: return a | b;
            default: return a;
        endcase
    endfunction

    // Behavioural arithmetic sum without carry, unreduced
    function automatic int ref_arith(input int s, input int a, input int b);
        int nb = (~b) & 15;
        case (s)
            0:  return a;
            1:  return a | b;
            2:  return a | nb;
            3:  return 15;
            4:  return a + (a & nb);
            5:  return (a | b) + (a & nb);
            6:  return a + nb;
            7:  return (a & nb) + 15;
            8:  return a + (a & b);
            9:  return a + b;
            10: return (a | nb) + (a & b);
            11: return (a & b) + 15;
            12: return a + a;
            13: return (a | b) + a;
            14: return (a | nb) + a;
            default: return a + 15;
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle inputs: code 0, arithmetic, no carry -> result A = 0
        chk("R3 idle result", int'(result), 0);
        chk("R5 idle carry_out_n", int'(carry_out_n), 1);
        chk("R7 idle all_ones", int'(all_ones), 0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        int f_hold = 0;
                        int p_hold = 0;
                        int g_hold = 0;
                        for (int cn = 1; cn >= 0; cn--) begin
                            int raw;
                            int tot;
                            int exp_f;
                            @(posedge clk);
                            #1;
                            logic_mode = m[0];
                            fn_sel     = 4'(s);
                            op_a       = 4'(a);
                            op_b       = 4'(b);
                            carry_in_n = cn[0];
                            @(negedge clk);
                            raw   = ref_arith(s, a, b);
                            tot   = raw + (1 - cn);
                            exp_f = (m == 1) ? ref_logic(s, a, b) : (tot % 16);
                            if (m == 1)
                                chk("R1 logic result", int'(result), exp_f);
                            else if (cn == 1)
                                chk("R3 arith result", int'(result), exp_f);
                            else
                                chk("R4 arith result with carry", int'(result), exp_f);
                            chk("R5 carry_out_n", int'(carry_out_n), (tot >= 16) ? 0 : 1);
                            chk("R6 gen_n", int'(gen_n), (raw >= 16) ? 0 : 1);
                            chk("R6 carry relation",
                                int'(!carry_out_n),
                                int'(!gen_n || (!prop_n && cn == 0)));
                            chk("R7 all_ones", int'(all_ones), (exp_f == 15) ? 1 : 0);
                            if (m == 0 && s == 6 && cn == 1) begin
                                chk("R7 equality", int'(all_ones), (a == b) ? 1 : 0);
                                chk("R8 greater", int'(!carry_out_n), (a > b) ? 1 : 0);
                                chk("R8 less", int'(carry_out_n && !all_ones), (a < b) ? 1 : 0);
                            end
                            if (cn == 1) begin
                                f_hold = int'(result);
                                p_hold = int'(prop_n);
                                g_hold = int'(gen_n);
                            end else begin
                                chk("R6 prop_n carry independent", int'(prop_n), p_hold);
                                chk("R6 gen_n carry independent", int'(gen_n), g_hold);
                                if (m == 1)
                                    chk("R2 logic ignores carry", int'(result), f_hold);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule